// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block keeps one 16-bit base register that places a 4 KB window of on-chip peripheral registers anywhere in a 24-bit address space. It watches every access on the bus, which consists of an address, a 3-bit address-space (function) code, read and write strobes, a word/byte size bit and a 16-bit write data bus. Reads and writes of the base register itself are served at the fixed byte address 0x0000F2. Every other access is compared against the stored window base, and can also be compared against a stored address-space code. The result is a single peripheral-select output.

The block starts with a fixed reset pattern in the register and keeps its decode disabled until software writes the register for the first time. Only word accesses from supervisor data space (code 101) can reach the register. A byte access from that space raises an error flag and changes nothing. All pins are plain level signals that are sampled on every clock. The bus strobes carry no handshake: the bus holds an access for as long as it needs, and the outputs follow it within the same cycle.

Register layout, where the decode depends on field position: bits 15..13 hold the address-space code to compare against, bit 12 enables that compare, and bits 11..0 are compared against address bits 23..12.

Top module: `rpd_decoder`

## Requirements
- R1: After reset, a supervisor-data-space (fc=101) word read of address 0x0000F2 returns 0xBFFF on `rdata` with `reg_hit` high.
- R2: The register responds only to accesses whose address bits 23..1 equal those of 0x0000F2 and whose fc is 101. Any other fc at that address gives `reg_hit`=0 and `rdata`=0, and a write leaves the stored value unchanged.
- R3: A supervisor word write stores `wdata` at the clock edge. A read returns the stored value in the same cycle. A new value takes effect in decodes from the next cycle on.
- R4: `periph_sel` stays low at every address and fc until the register has been written successfully at least once after reset.
- R5: With bit 12 = 0, `periph_sel` is high for a strobed access exactly when address bits 23..12 equal register bits 11..0. The stored fc field plays no part.
- R6: With bit 12 = 1, a window match also requires the bus fc to equal register bits 15..13.
- R7: An access with fc=111 never asserts `periph_sel`, even when the stored fc field is 111.
- R8: A byte access (`word`=0) with fc=101 at the register address raises `acc_err`, leaves the register unchanged and gives `rdata`=0.
- R9: An access whose address bits 23..1 equal those of 0x0000F2 never asserts `periph_sel`, whatever its fc.
- R10: With neither `rd` nor `wr` high, `periph_sel`, `reg_hit` and `acc_err` are all low. At most one of the three is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 24 | Byte address of the current access |
| fc | input | 3 | Address-space code of the current access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| word | input | 1 | 1 = word access, 0 = byte access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Register read data, 0 when the register is not being read |
| reg_hit | output | 1 | A valid register access is in progress |
| acc_err | output | 1 | Byte access to the register by supervisor data space |
| periph_sel | output | 1 | Access falls inside the programmed peripheral window |

## Verification
The bench builds the decoder with its default parameters: a 24-bit address, 16-bit data, register address 0x0000F2 and a 12-bit window base. These values let it reach the register address from inside a window based at zero, so the priority of R9 can be tested. A behavioural model keeps its own copy of the register value and an armed flag, and predicts all four outputs in every cycle. It covers the gaps between a write and the decode that follows, user-space and byte attempts to change the register, and the fc=111 exclusion both with and without the fc compare.

// File: rtl/rpd_pkg.sv
package rpd_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,
    ACC_REG_OK  = 3'd1,
    ACC_REG_BAD = 3'd2,
    ACC_REG_DENY = 3'd3,
    ACC_OTHER   = 3'd4
  } acc_kind_t;

  localparam int unsigned DEF_ADDR_W = 24;
  localparam int unsigned DEF_FC_W   = 3;
  localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/rpd_access_decode.sv
module rpd_access_decode
  import rpd_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned FC_W   = DEF_FC_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = 24'h0000F2,
  parameter logic [FC_W-1:0]   SUPV_FC  = 3'b101
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [FC_W-1:0]   fc,
  input  logic              rd,
  input  logic              wr,
  input  logic              word,
  output logic              at_reg,
  output acc_kind_t         kind
);
  // word-granular match: both byte lanes of the register hit
  assign at_reg = (addr[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1]);

  always_comb begin
    if (!(rd || wr))            kind = ACC_IDLE;
    else if (!at_reg)           kind = ACC_OTHER;
    else if (fc != SUPV_FC)     kind = ACC_REG_DENY;
    else if (word)              kind = ACC_REG_OK;
    else                        kind = ACC_REG_BAD;
  end

  always_comb begin
    if (kind == ACC_REG_OK) a_r2_only_supv_word: assert (fc == SUPV_FC && word);
  end
endmodule

// File: rtl/rpd_base_reg.sv
module rpd_base_reg #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] RESET_VAL = 16'hBFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= RESET_VAL;
      armed <= 1'b0;
    end else if (we) begin
      value <= wdata;
      armed <= 1'b1;
    end
  end

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (value == $past(wdata)));
  a_r4_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  a_r4_armed_by_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !we) |=> !armed);
endmodule

// File: rtl/rpd_window_match.sv
module rpd_window_match #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned FC_W   = 3,
  parameter int unsigned BASE_W = 12,
  parameter logic [FC_W-1:0] IACK_FC = 3'b111
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [FC_W-1:0]   fc,
  input  logic [FC_W-1:0]   fc_field,
  input  logic              cfc,
  input  logic [BASE_W-1:0] base,
  input  logic              enable,
  output logic              hit
);
  localparam int unsigned WIN_LSB = ADDR_W - BASE_W;

  logic [BASE_W-1:0] bit_eq;
  for (genvar i = 0; i < BASE_W; i++) begin : g_cmp
    assign bit_eq[i] = ~(addr[WIN_LSB+i] ^ base[i]);
  end

  logic addr_ok, fc_ok, space_ok;
  assign addr_ok  = &bit_eq;
  assign fc_ok    = !cfc || (fc == fc_field);
  assign space_ok = (fc != IACK_FC);
  assign hit      = enable && addr_ok && fc_ok && space_ok;

  always_comb begin
    if (fc == IACK_FC) a_r7_iack_no_hit: assert (!hit);
    if (!enable)       a_r4_disabled_no_hit: assert (!hit);
  end
endmodule

// File: rtl/rpd_decoder.sv
module rpd_decoder
  import rpd_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned FC_W   = DEF_FC_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 24'h0000F2,
  parameter logic [FC_W-1:0]   SUPV_FC   = 3'b101,
  parameter logic [FC_W-1:0]   IACK_FC   = 3'b111,
  parameter logic [DATA_W-1:0] RESET_VAL = 16'hBFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FC_W-1:0]   fc,
  input  logic              rd,
  input  logic              wr,
  input  logic              word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              reg_hit,
  output logic              acc_err,
  output logic              periph_sel
);
  localparam int unsigned BASE_W  = DATA_W - FC_W - 1;
  localparam int unsigned CFC_BIT = BASE_W;
  localparam int unsigned FC_LSB  = BASE_W + 1;

  acc_kind_t         kind;
  logic              at_reg;
  logic              we;
  logic              armed;
  logic [DATA_W-1:0] reg_value;
  logic              win_hit;

  rpd_access_decode #(
    .ADDR_W(ADDR_W), .FC_W(FC_W), .REG_ADDR(REG_ADDR), .SUPV_FC(SUPV_FC)
  ) u_acc (
    .addr(addr), .fc(fc), .rd(rd), .wr(wr), .word(word),
    .at_reg(at_reg), .kind(kind)
  );

  assign we = (kind == ACC_REG_OK) && wr;

  rpd_base_reg #(
    .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata),
    .value(reg_value), .armed(armed)
  );

  rpd_window_match #(
    .ADDR_W(ADDR_W), .FC_W(FC_W), .BASE_W(BASE_W), .IACK_FC(IACK_FC)
  ) u_win (
    .addr(addr), .fc(fc),
    .fc_field(reg_value[DATA_W-1:FC_LSB]),
    .cfc(reg_value[CFC_BIT]),
    .base(reg_value[BASE_W-1:0]),
    .enable(armed),
    .hit(win_hit)
  );

  assign periph_sel = (kind == ACC_OTHER) && win_hit;
  assign reg_hit    = (kind == ACC_REG_OK);
  assign acc_err    = (kind == ACC_REG_BAD);
  assign rdata      = (reg_hit && rd) ? reg_value : '0;

  a_r9_reg_addr_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    at_reg |-> !periph_sel);
  a_r4_no_sel_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !periph_sel);
  a_r2_foreign_space_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (at_reg && (rd || wr) && fc != SUPV_FC) |=> $stable(reg_value));
  a_r8_byte_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> $stable(reg_value));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd || wr) |-> !(periph_sel || reg_hit || acc_err));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({periph_sel, reg_hit, acc_err}));
endmodule

// File: tb/rpd_decoder_test.sv
module rpd_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  fc = '0;
  logic        rd = 1'b0, wr = 1'b0, word = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        reg_hit, acc_err, periph_sel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_val;
  bit m_armed;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpd_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .fc(fc), .rd(rd), .wr(wr),
    .word(word), .wdata(wdata), .rdata(rdata), .reg_hit(reg_hit),
    .acc_err(acc_err), .periph_sel(periph_sel)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive after falling edge, compare, then model the edge
  task automatic cyc(string tag, bit r, bit w, bit wd, int f, int a, int d);
    int e_rdata; bit e_hit, e_err, e_sel, is_reg, strobe;
    @(negedge clk);
    rd = r; wr = w; word = wd; fc = 3'(f); addr = 24'(a); wdata = 16'(d);
    #2;
    strobe = r || w;
    is_reg = ((a / 2) == (24'hF2 / 2));
    e_hit = strobe && is_reg && f == 5 && wd;
    e_err = strobe && is_reg && f == 5 && !wd;
    e_rdata = (e_hit && r) ? m_val : 0;
    e_sel = 0;
    if (strobe && !is_reg && m_armed && f != 7 &&
        ((a >> 12) & 'hFFF) == (m_val & 'hFFF)) begin
      if (((m_val >> 12) & 1) == 0) e_sel = 1;
      else if (((m_val >> 13) & 7) == f) e_sel = 1;
    end
    check(tag, "rdata", int'(rdata), e_rdata);
    check(tag, "reg_hit", int'(reg_hit), int'(e_hit));
    check(tag, "acc_err", int'(acc_err), int'(e_err));
    check(tag, "periph_sel", int'(periph_sel), int'(e_sel));
    @(posedge clk);
    if (e_hit && w) begin
      m_val = d & 'hFFFF;
      m_armed = 1;
    end
  endtask

  initial begin
    m_val = 'hBFFF;
    m_armed = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset periph_sel", int'(periph_sel), 0);
    check("R10", "reset reg_hit", int'(reg_hit), 0);
    rst_n = 1'b1;
    cyc("R10", 0, 0, 1, 5, 'h0000F2, 0);
    cyc("R1", 1, 0, 1, 5, 'h0000F2, 0);
    // R4: window matching reset pattern, not yet armed
    cyc("R4", 1, 0, 1, 5, 'hFFF123, 0);
    cyc("R4", 0, 1, 1, 5, 'hFFF000, 0);
    cyc("R4", 1, 0, 1, 1, 'hABC000, 0);
    // R2: user-space write does not reach the register
    cyc("R2", 0, 1, 1, 1, 'h0000F2, 'h1234);
    cyc("R2", 1, 0, 1, 1, 'h0000F2, 0);
    cyc("R2", 1, 0, 1, 5, 'h0000F2, 0);
    cyc("R4", 1, 0, 1, 5, 'hFFF010, 0);
    // R8: byte writes and reads by supervisor data space
    cyc("R8", 0, 1, 0, 5, 'h0000F2, 'h0123);
    cyc("R8", 1, 0, 0, 5, 'h0000F3, 0);
    cyc("R8", 1, 0, 1, 5, 'h0000F2, 0);
    cyc("R4", 1, 0, 1, 5, 'h012000, 0);
    // R3: word write, base 0x123, no fc compare
    cyc("R3", 0, 1, 1, 5, 'h0000F2, 'h0123);
    cyc("R3", 1, 0, 1, 5, 'h0000F2, 0);
    cyc("R5", 1, 0, 1, 1, 'h123456, 0);
    cyc("R5", 0, 1, 1, 5, 'h123FFF, 0);
    cyc("R5", 1, 0, 1, 2, 'h123000, 0);
    cyc("R7", 1, 0, 1, 7, 'h123456, 0);
    cyc("R5", 1, 0, 1, 1, 'h124000, 0);
    cyc("R5", 1, 0, 1, 1, 'h122FFF, 0);
    cyc("R10", 0, 0, 1, 1, 'h123456, 0);
    // R6: compare enabled, space 001
    cyc("R3", 0, 1, 1, 5, 'h0000F2, 'h3123);
    cyc("R6", 1, 0, 1, 1, 'h123000, 0);
    cyc("R6", 1, 0, 1, 5, 'h123000, 0);
    cyc("R6", 0, 1, 1, 2, 'h123ABC, 0);
    // R3: relocation takes effect the cycle after the write
    cyc("R3", 0, 1, 1, 5, 'h0000F2, 'h3456);
    cyc("R3", 1, 0, 1, 1, 'h123000, 0);
    cyc("R3", 1, 0, 1, 1, 'h456789, 0);
    // R7: stored fc field 111 with compare
    cyc("R7", 0, 1, 1, 5, 'h0000F2, 'hF000);
    cyc("R7", 1, 0, 1, 7, 'h000100, 0);
    cyc("R9", 1, 0, 1, 7, 'h0000F2, 0);
    // R9: window at zero covers the register address
    cyc("R3", 0, 1, 1, 5, 'h0000F2, 'h0000);
    cyc("R9", 1, 0, 1, 1, 'h0000F2, 0);
    cyc("R9", 0, 1, 0, 1, 'h0000F3, 'hFFFF);
    cyc("R9", 1, 0, 1, 1, 'h0000F0, 0);
    cyc("R9", 1, 0, 1, 5, 'h0000F4, 0);
    cyc("R7", 1, 0, 1, 7, 'h0000F0, 0);
    cyc("R2", 1, 0, 1, 5, 'h0000F2, 0);
    cyc("R10", 0, 0, 1, 5, 'h0000F2, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule